// File: doc/BRIEF.md
# Merging Write-Through Store Buffer

This block sits between a write-through cache and main memory and holds outgoing stores in a small number of block-sized entries. Each entry covers one aligned block of several 64-bit words and has a valid bit per word. A store whose block already has an entry that is still open is folded into that entry. Otherwise the store opens a new entry at the tail of the queue. When every entry is in use and the store cannot be folded, the store is held off with ready low. Entries leave through the memory port strictly in arrival order. Each one goes out as a single block write that carries a per-word valid mask, so memory sees fewer and wider writes.

A store can be flagged as non-mergeable, for example a store to a device region. Such a store always gets an entry of its own and no later store is ever folded into that entry. The oldest entry is offered to memory as soon as it exists. From then on that entry is closed, and a later store to the same block opens a new entry. A combinational read-lookup port lets a read miss look for pending data. It returns the newest buffered copy of the addressed word in the same cycle, and it is never blocked by stalled stores or by a slow memory port. The entry count must be a power of two, at least 2.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: mw_valid is 0, st_ready is 1 and rd_hit is 0.
- R2: A store accepted into an empty buffer, or one that cannot merge, opens a new entry. The entry is offered with mw_addr equal to the store's byte address with bits [4:0] cleared. Word index k is address bits [4:3]. The data sits in mw_data[64k+63:64k] and only mask bit k is set.
- R3: A mergeable store to the block of an open entry, meaning valid, not the head and not flagged non-mergeable, joins that entry. The mask becomes the OR of both word bits and no new entry is used.
- R4: A merge into a word that is already valid in the entry replaces that word's data with the newer store.
- R5: When all 4 entries are used, st_ready is 0 for a store that cannot merge and 1 for one that can. A stalled store is accepted once an entry has left, from the cycle after that hand-off.
- R6: A store with st_nomerge=1 never merges and always opens an entry of its own. No later store merges into such an entry.
- R7: Entries are offered on the memory port oldest first. While mw_valid=1 and mw_ready=0, mw_addr, mw_mask and mw_data hold steady. A hand-off (mw_valid and mw_ready both high at a clock edge) frees the entry.
- R8: The head entry is being offered to memory and is closed. A store to its block opens a new entry even if the word differs.
- R9: The read lookup is combinational. rd_hit=1 only when some entry holds a valid copy of the addressed word. rd_data is then the copy from the newest such entry. The lookup works while stores are stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data word |
| st_nomerge | input | 1 | Store targets a region that must not be combined |
| mw_valid | output | 1 | Oldest entry offered to memory |
| mw_ready | input | 1 | Memory takes the offered entry |
| mw_addr | output | ADDR_W | Block-aligned byte address of the offered entry |
| mw_data | output | WORDS*DATA_W | Word slots of the offered entry |
| mw_mask | output | WORDS | Per-word valid mask of the offered entry |
| rd_addr | input | ADDR_W | Read-miss lookup byte address |
| rd_hit | output | 1 | A buffered copy of the word exists |
| rd_data | output | DATA_W | Newest buffered copy of the word |

## Verification
The stores are sent while memory is held off, so all merging decisions stay visible. The sequence has stores to two blocks on different words, a second store to a word that is already valid, and a store to the head's block. It also has a non-mergeable store that fills the buffer, followed by a merge into the full buffer. The order and masks of the block writes that follow tell a correct merge apart from a new entry, a lost overwrite, and a wrong merge into the closed head. A second run interleaves non-mergeable and normal stores to one block, which tells whether the no-merge flag is honoured in both directions. Read lookups while the store port is stalled tell apart newest-copy selection, a miss on an invalid word in a present block, and forwarding after draining.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned BYTE_OFF   = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_MERGE = 2'd2
  } st_act_e;
endpackage

// File: rtl/mwb_match.sv
module mwb_match #(
  parameter int N     = 4,
  parameter int TAG_W = 27
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            qual,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = qual[i] && (tags[i] == key);
  end
endmodule

// File: rtl/mwb_pick.sv
module mwb_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  hit,
  input  logic [PW-1:0] head,
  output logic          found,
  output logic [PW-1:0] idx
);
  // walk from oldest to newest; the last hit seen is the youngest
  always_comb begin
    found = 1'b0;
    idx   = head;
    for (int k = 0; k < N; k++) begin
      if (hit[head + PW'(k)]) begin
        found = 1'b1;
        idx   = head + PW'(k);
      end
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import mwb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic                    st_nomerge,
  output logic                    mw_valid,
  input  logic                    mw_ready,
  output logic [ADDR_W-1:0]       mw_addr,
  output logic [WORDS*DATA_W-1:0] mw_data,
  output logic [WORDS-1:0]        mw_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_hit,
  output logic [DATA_W-1:0]       rd_data
);
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int BLK_OFF = BYTE_OFF + WIDX_W;
  localparam int TAG_W   = ADDR_W - BLK_OFF;
  localparam int PW      = $clog2(ENTRIES);
  localparam int CW      = PW + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // entry storage
  logic [ENTRIES-1:0][TAG_W-1:0]             tag_q, tag_d;
  logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0] dat_q, dat_d;
  logic [ENTRIES-1:0][WORDS-1:0]             msk_q, msk_d;
  logic [ENTRIES-1:0]                        nm_q, nm_d;
  logic [ENTRIES-1:0]                        vld_q, vld_d;
  logic [ENTRIES-1:0]                        ent_en;
  logic [PW-1:0]                             head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]                             cnt_q, cnt_d;

  // address split
  logic [TAG_W-1:0]  st_tag, rd_tag;
  logic [WIDX_W-1:0] st_word, rd_word;
  logic              unused_lo;
  assign st_tag    = st_addr[ADDR_W-1:BLK_OFF];
  assign st_word   = st_addr[BLK_OFF-1:BYTE_OFF];
  assign rd_tag    = rd_addr[ADDR_W-1:BLK_OFF];
  assign rd_word   = rd_addr[BLK_OFF-1:BYTE_OFF];
  assign unused_lo = ^{st_addr[BYTE_OFF-1:0], rd_addr[BYTE_OFF-1:0]};

  // qualifiers: open for merging, and word present for lookup
  logic [ENTRIES-1:0] open_ent, rd_qual;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      open_ent[i] = vld_q[i] && !nm_q[i] && (PW'(i) != head_q);
      rd_qual[i]  = vld_q[i] && msk_q[i][rd_word];
    end
  end

  logic [ENTRIES-1:0] st_hits, rd_hits;
  logic               mrg_found, rd_found;
  logic [PW-1:0]      mrg_idx, rd_idx;

  mwb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_st_match (
    .tags(tag_q), .qual(open_ent), .key(st_tag), .hit(st_hits));
  mwb_pick #(.N(ENTRIES), .PW(PW)) u_st_pick (
    .hit(st_hits), .head(head_q), .found(mrg_found), .idx(mrg_idx));
  mwb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_rd_match (
    .tags(tag_q), .qual(rd_qual), .key(rd_tag), .hit(rd_hits));
  mwb_pick #(.N(ENTRIES), .PW(PW)) u_rd_pick (
    .hit(rd_hits), .head(head_q), .found(rd_found), .idx(rd_idx));

  assign rd_hit  = rd_found;
  assign rd_data = dat_q[rd_idx][rd_word];

  // store-side decision
  logic    full, merge_ok, pop;
  st_act_e act;
  assign full     = (cnt_q == CW'(ENTRIES));
  assign merge_ok = mrg_found && !st_nomerge;
  assign st_ready = merge_ok || !full;

  always_comb begin
    act = ACT_NONE;
    if (st_valid && st_ready) act = merge_ok ? ACT_MERGE : ACT_ALLOC;
  end

  // memory side: head is always the one on offer
  assign mw_valid = vld_q[head_q];
  assign mw_addr  = {tag_q[head_q], {BLK_OFF{1'b0}}};
  assign mw_data  = dat_q[head_q];
  assign mw_mask  = msk_q[head_q];
  assign pop      = mw_valid && mw_ready;

  // next state
  logic [WORDS-1:0] word_oh;
  assign word_oh = WORDS'(1) << st_word;

  always_comb begin
    vld_d  = vld_q;
    nm_d   = nm_q;
    tag_d  = tag_q;
    msk_d  = msk_q;
    dat_d  = dat_q;
    head_d = head_q;
    tail_d = tail_q;
    if (pop) begin
      vld_d[head_q] = 1'b0;
      head_d        = head_q + PW'(1);
    end
    case (act)
      ACT_ALLOC: begin
        vld_d[tail_q]          = 1'b1;
        nm_d[tail_q]           = st_nomerge;
        tag_d[tail_q]          = st_tag;
        msk_d[tail_q]          = word_oh;
        dat_d[tail_q][st_word] = st_data;
        tail_d                 = tail_q + PW'(1);
      end
      ACT_MERGE: begin
        msk_d[mrg_idx]          = msk_q[mrg_idx] | word_oh;
        dat_d[mrg_idx][st_word] = st_data;
      end
      default: ;
    endcase
    cnt_d = cnt_q + CW'(act == ACT_ALLOC) - CW'(pop);
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ent_en[i] = ((act == ACT_ALLOC) && (tail_q == PW'(i))) ||
                  ((act == ACT_MERGE) && (mrg_idx == PW'(i)));
    end
  end

  // registers: control with reset, payload with enable only
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (ent_en[i]) begin
        tag_q[i] <= tag_d[i];
        dat_q[i] <= dat_d[i];
        msk_q[i] <= msk_d[i];
        nm_q[i]  <= nm_d[i];
      end
    end
  end
endmodule

// File: rtl/mwb_chk.sv
module mwb_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int CW      = 3
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic                    st_ready,
  input logic                    mw_valid,
  input logic                    mw_ready,
  input logic [ADDR_W-1:0]       mw_addr,
  input logic [WORDS*DATA_W-1:0] mw_data,
  input logic [WORDS-1:0]        mw_mask,
  input logic                    rd_hit,
  input logic [CW-1:0]           cnt,
  input logic                    head_nm
);
  // R1 / R7: an offer exists exactly when entries are held
  a_r1_empty_no_offer: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt == '0) == !mw_valid);

  // R5: stores are refused only when every entry is used
  a_r5_stall_only_full: assert property (@(posedge clk) disable iff (!rst_ni)
    !st_ready |-> (cnt == CW'(ENTRIES)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt <= CW'(ENTRIES));

  // R7 / R8: an offer not taken stays unchanged (head is closed to merges)
  a_r7_offer_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) &&
                                 $stable(mw_mask) && $stable(mw_data)));

  a_r7_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_ni)
    mw_valid |-> (mw_mask != '0));

  // R6: a non-mergeable entry carries a single word
  a_r6_nomerge_single: assert property (@(posedge clk) disable iff (!rst_ni)
    (mw_valid && head_nm) |-> ($countones(mw_mask) == 1));

  // R9: a lookup hit needs a held entry
  a_r9_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_hit |-> (cnt != '0));
endmodule

bind merge_wbuf mwb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .WORDS(WORDS), .CW(CW)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .st_ready(st_ready), .mw_valid(mw_valid),
  .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .mw_mask(mw_mask),
  .rd_hit(rd_hit), .cnt(cnt_q), .head_nm(nm_q[head_q])
);

// File: tb/merge_wbuf_tb.sv
`timescale 1ns/1ps
module merge_wbuf_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, st_ready, st_nomerge;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic         mw_valid, mw_ready;
  logic [31:0]  mw_addr;
  logic [255:0] mw_data;
  logic [3:0]   mw_mask;
  logic [31:0]  rd_addr;
  logic         rd_hit;
  logic [63:0]  rd_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  merge_wbuf u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_nomerge(st_nomerge),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_mask(mw_mask),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  // stores: {nomerge, addr, data}
  localparam logic [96:0] ST_VEC [6] = '{
    {1'b0, 32'h0000_0100, 64'hA000_0000_0000_0000},  // new entry (head)
    {1'b0, 32'h0000_0208, 64'hA100_0000_0000_0001},  // new entry, word 1
    {1'b0, 32'h0000_0218, 64'hA200_0000_0000_0002},  // merge, word 3
    {1'b0, 32'h0000_0100, 64'hA300_0000_0000_0003},  // head block: new entry
    {1'b1, 32'h0000_0300, 64'hA400_0000_0000_0004},  // no-merge, fills buffer
    {1'b0, 32'h0000_0208, 64'hA500_0000_0000_0005}   // merge into full buffer, overwrite
  };
  // expected block writes: {addr, mask, w3, w2, w1, w0}
  localparam logic [291:0] DR_VEC [4] = '{
    {32'h0000_0100, 4'b0001, 64'h0, 64'h0, 64'h0, 64'hA000_0000_0000_0000},
    {32'h0000_0200, 4'b1010, 64'hA200_0000_0000_0002, 64'h0,
                             64'hA500_0000_0000_0005, 64'h0},
    {32'h0000_0100, 4'b0001, 64'h0, 64'h0, 64'h0, 64'hA300_0000_0000_0003},
    {32'h0000_0300, 4'b0001, 64'h0, 64'h0, 64'h0, 64'hA400_0000_0000_0004}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_store(input logic nm, input logic [31:0] a,
                          input logic [63:0] d, input string req);
    int n = 0;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_nomerge = nm;
    #1;
    while (!st_ready && n < 20) begin
      @(negedge clk); #1; n++;
    end
    check(st_ready == 1'b1, req, "store accepted", 256'(st_ready), 256'(1));
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic probe_ready(input logic nm, input logic [31:0] a,
                             input logic exp, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = 64'hDEAD; st_nomerge = nm;
    #1;
    check(st_ready == exp, req, "st_ready", 256'(st_ready), 256'(exp));
    st_valid = 1'b0;
  endtask

  task automatic rd_check(input logic [31:0] a, input logic eh,
                          input logic [63:0] ed, input string req);
    rd_addr = a;
    #1;
    check((rd_hit == eh) && (!eh || rd_data == ed), req, "lookup",
          {rd_hit, rd_data}, {eh, ed});
  endtask

  task automatic do_drain(input logic [291:0] row, input string req);
    int  n = 0;
    bit  ok;
    @(negedge clk);
    while (!mw_valid && n < 20) begin
      @(negedge clk); n++;
    end
    ok = mw_valid && (mw_addr == row[291:260]) && (mw_mask == row[259:256]);
    for (int w = 0; w < 4; w++)
      if (row[256 + w] && (mw_data[64*w +: 64] != row[64*w +: 64])) ok = 1'b0;
    check(ok, req, "block write", {mw_valid, mw_addr, mw_mask, mw_data[63:0]},
          {1'b1, row[291:256], row[63:0]});
    mw_ready = 1'b1;
    @(posedge clk); #1;
    mw_ready = 1'b0;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
    st_nomerge = 1'b0; mw_ready = 1'b0; rd_addr = 32'h100;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(mw_valid == 1'b0, "R1", "mw_valid", 256'(mw_valid), 256'(0));
    check(st_ready == 1'b1, "R1", "st_ready", 256'(st_ready), 256'(1));
    rd_check(32'h100, 1'b0, 64'h0, "R1");

    // vector walk: R2 R3 R4 R5 R6 R8 with memory held off
    for (int i = 0; i < 6; i++)
      do_store(ST_VEC[i][96], ST_VEC[i][95:64], ST_VEC[i][63:0], "R2_R3_R5");

    // R5: full, non-mergeable store stalls; R6: flagged store cannot merge
    probe_ready(1'b0, 32'h400, 1'b0, "R5");
    probe_ready(1'b1, 32'h208, 1'b0, "R6");
    probe_ready(1'b0, 32'h210, 1'b1, "R5");

    // R9 lookups during stall
    @(negedge clk);
    rd_check(32'h208, 1'b1, 64'hA500_0000_0000_0005, "R4");
    rd_check(32'h218, 1'b1, 64'hA200_0000_0000_0002, "R3");
    rd_check(32'h100, 1'b1, 64'hA300_0000_0000_0003, "R9");
    rd_check(32'h110, 1'b0, 64'h0, "R9");
    rd_check(32'h300, 1'b1, 64'hA400_0000_0000_0004, "R9");

    // R7 hold while memory not ready, then first drain
    repeat (3) @(negedge clk);
    do_drain(DR_VEC[0], "R7");
    probe_ready(1'b0, 32'h400, 1'b1, "R5");
    do_drain(DR_VEC[1], "R3_R4");
    do_drain(DR_VEC[2], "R8");
    do_drain(DR_VEC[3], "R6");
    @(negedge clk);
    check(mw_valid == 1'b0, "R7", "empty after drains", 256'(mw_valid), 256'(0));
    rd_check(32'h208, 1'b0, 64'h0, "R9");

    // directed: no-merge flag in both directions (R6)
    do_store(1'b0, 32'h600, 64'hB000_0000_0000_0000, "R2");
    do_store(1'b1, 32'h500, 64'hB100_0000_0000_0001, "R6");
    do_store(1'b0, 32'h508, 64'hB200_0000_0000_0002, "R6");
    do_store(1'b1, 32'h510, 64'hB300_0000_0000_0003, "R6");
    do_drain({32'h600, 4'b0001, 192'h0, 64'hB000_0000_0000_0000}, "R7");
    do_drain({32'h500, 4'b0001, 192'h0, 64'hB100_0000_0000_0001}, "R6");
    do_drain({32'h500, 4'b0010, 128'h0, 64'hB200_0000_0000_0002, 64'h0}, "R6");
    do_drain({32'h500, 4'b0100, 64'h0, 64'hB300_0000_0000_0003, 128'h0}, "R6");
    @(negedge clk);
    check(mw_valid == 1'b0, "R6", "empty after no-merge run", 256'(mw_valid), 256'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule